// File: doc/BRIEF.md
# Block Erase Sequencer with Suspend and Resume

This block performs the erase of one block of a word-organised array under command control. An erase command selects a target block and the block is latched at that moment. The sequencer then runs four phases across every word of the block, in fixed order: it writes all-zeros, verifies the zeros, writes all-ones, and verifies the ones. Each write pulse lasts a configurable number of cycles. This stands in for the long, internally timed cell operations of a real memory, and the array itself is reached through a plain behavioural port with one-cycle read latency.

A host can ask the sequencer to pause. The pause takes effect only when the current word or phase is finished. The host learns that the pause has happened by watching the status byte. While paused, the host may read any block except the one being erased. A resume request continues from the exact word and phase that were saved. A verify mismatch causes the same word to be rewritten, up to a bounded number of retries. When that budget runs out, the erase ends and an erase-failure flag is set.

Top module: `erase_seq`

## Requirements
- R1: When the block is idle, a `cmd_erase` pulse latches `cmd_blk` as the target, and every array write of that erase lands inside the target block (upper `arr_addr` bits equal to the target).
- R2: The phases run in this order: all words written 0, all words verified 0, all words written all-ones, all words verified all-ones. An erase with no faults issues exactly 2 × `BLK_WORDS` writes, and the array port never reads and writes in the same cycle.
- R3: After a successful erase, every word of the target block holds all-ones, the other blocks are unchanged, `sts` = 0x80 and `done` = 1.
- R4: A verify mismatch rewrites the same word with the phase's pattern and reads it again, up to `MAX_RETRY` (default 3) times. A word that recovers within this budget does not fail the erase. Each retry adds one write.
- R5: A mismatch after `MAX_RETRY` retries, in either verify phase, ends the erase at once with `sts` bit 5 set (`sts` = 0xA0) and `done` = 1.
- R6: `cmd_suspend` while busy takes effect only after the word in progress completes. After that point `sts` = 0xC0 (bit 7 ready, bit 6 suspended), and no array write occurs while suspended.
- R7: `cmd_resume` while suspended clears bit 6 and bit 7 on the next cycle, and the erase restarts at the saved word and phase. The total write count equals that of an uninterrupted erase.
- R8: A `host_rd` is granted only while idle or suspended, and while suspended only to a block other than the target. A granted read gives `host_rvalid` = 1 and `host_rdata` one cycle later. A refused read gives `host_rerr` = 1 one cycle later and no `host_rvalid`.
- R9: `cmd_erase` while busy or suspended is ignored: the target is unchanged and the named block is not written.
- R10: After reset, `sts` = 0x80, `done` = 0, and the array port is not strobed. A reset in the middle of an erase returns the block to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_erase | input | 1 | Erase confirm pulse |
| cmd_blk | input | BLK_W | Block index (upper address bits) of the erase |
| cmd_suspend | input | 1 | Suspend request pulse |
| cmd_resume | input | 1 | Resume request pulse |
| host_rd | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host read word address |
| host_rdata | output | DATA_W | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Host read granted, data valid |
| host_rerr | output | 1 | Host read refused |
| sts | output | 8 | Status: bit 7 ready, bit 6 suspended, bit 5 erase failed |
| done | output | 1 | Last erase has ended (pass or fail) |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array read data, one cycle after arr_re |

## Verification
The hardest case to reach from the ports is a suspend that arrives in the middle of a write pulse. The pause must wait until that word's pulse ends and must then resume without repeating or skipping a word. To get there, the bench waits for a visible write strobe and raises the suspend request in that same cycle. It then checks that the suspended flag is still low one cycle later and that exactly two words had been written when the pause took effect. After the resume, it checks that the total write count matches an erase that was never interrupted. Retry and failure paths are reached with a behavioural array model in the bench that can hold one bit stuck at 0 or 1, or drop the first all-ones write to one word.

// File: rtl/esq_pkg.sv
`timescale 1ns/1ps
package esq_pkg;
  typedef enum logic [1:0] {PH_PGM, PH_PV, PH_ERS, PH_EV} phase_e;
  typedef enum logic [2:0] {S_IDLE, S_WR, S_WAIT, S_RD, S_CHK, S_SUSP} state_e;

  localparam int STS_READY = 7;
  localparam int STS_SUSP  = 6;
  localparam int STS_EFAIL = 5;

  function automatic state_e entry_of(phase_e p);
    return (p == PH_PGM || p == PH_ERS) ? S_WR : S_RD;
  endfunction
endpackage

// File: rtl/esq_pulse_timer.sv
`timescale 1ns/1ps
module esq_pulse_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(CYC - 1));
endmodule

// File: rtl/esq_host_gate.sv
`timescale 1ns/1ps
module esq_host_gate #(
  parameter int BLK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_win,
  input  logic             guard_en,
  input  logic [BLK_W-1:0] guard_blk,
  input  logic             host_rd,
  input  logic [BLK_W-1:0] host_blk,
  output logic             grant,
  output logic             rvalid,
  output logic             rerr
);
  assign grant = host_rd && open_win && !(guard_en && host_blk == guard_blk);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rerr   <= 1'b0;
    end else begin
      rvalid <= grant;
      rerr   <= host_rd && !grant;
    end
  end
endmodule

// File: rtl/esq_ctrl.sv
`timescale 1ns/1ps
module esq_ctrl
  import esq_pkg::*;
#(
  parameter int BLK_W     = 2,
  parameter int OFF_W     = 3,
  parameter int BLK_WORDS = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_RETRY = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_erase,
  input  logic [BLK_W-1:0]       cmd_blk,
  input  logic                   cmd_suspend,
  input  logic                   cmd_resume,
  input  logic                   tmr_expire,
  output logic                   tmr_run,
  input  logic [DATA_W-1:0]      rdata,
  output logic                   seq_we,
  output logic                   seq_re,
  output logic [BLK_W+OFF_W-1:0] seq_addr,
  output logic [DATA_W-1:0]      seq_wdata,
  output logic [BLK_W-1:0]       tgt_blk,
  output logic                   is_idle,
  output logic                   is_susp,
  output logic                   fail_q,
  output logic                   done_q
);
  localparam int RW = $clog2(MAX_RETRY + 1);

  state_e            state;
  phase_e            phase, nxt_phase;
  logic [OFF_W-1:0]  off;
  logic [RW-1:0]     retry;
  logic              pend;
  logic [DATA_W-1:0] pat;
  logic              last_off, match, adv, fin, is_write_ph;

  assign is_write_ph = (phase == PH_PGM) || (phase == PH_ERS);
  assign pat         = (phase == PH_PGM || phase == PH_PV) ? '0 : '1;
  assign last_off    = (off == OFF_W'(BLK_WORDS - 1));
  assign match       = (rdata == pat);
  assign adv         = (state == S_WAIT && tmr_expire && is_write_ph) ||
                       (state == S_CHK && match);
  assign fin         = adv && last_off && (phase == PH_EV);
  assign nxt_phase   = last_off ? phase_e'(phase + 2'd1) : phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      phase  <= PH_PGM;
      off    <= '0;
      retry  <= '0;
      pend   <= 1'b0;
      tgt_blk <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cmd_suspend && state != S_IDLE && state != S_SUSP) pend <= 1'b1;
      if (fin) begin
        state  <= S_IDLE;
        done_q <= 1'b1;
        pend   <= 1'b0;
      end else if (adv) begin
        off   <= last_off ? '0 : off + 1'b1;
        phase <= nxt_phase;
        retry <= '0;
        pend  <= 1'b0;
        state <= (pend || cmd_suspend) ? S_SUSP : entry_of(nxt_phase);
      end else begin
        case (state)
          S_IDLE: if (cmd_erase) begin
            tgt_blk <= cmd_blk;
            phase   <= PH_PGM;
            off     <= '0;
            retry   <= '0;
            pend    <= 1'b0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
            state   <= S_WR;
          end
          S_WR:   state <= S_WAIT;
          S_WAIT: if (tmr_expire) state <= S_RD;
          S_RD:   state <= S_CHK;
          S_CHK: begin
            if (retry < RW'(MAX_RETRY)) begin
              retry <= retry + 1'b1;
              state <= S_WR;
            end else begin
              fail_q <= 1'b1;
              done_q <= 1'b1;
              pend   <= 1'b0;
              state  <= S_IDLE;
            end
          end
          S_SUSP: if (cmd_resume) begin
            pend  <= 1'b0;
            state <= entry_of(phase);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign tmr_run   = (state == S_WAIT);
  assign seq_we    = (state == S_WR);
  assign seq_re    = (state == S_RD);
  assign seq_addr  = {tgt_blk, off};
  assign seq_wdata = pat;
  assign is_idle   = (state == S_IDLE);
  assign is_susp   = (state == S_SUSP);
endmodule

// File: rtl/erase_seq.sv
`timescale 1ns/1ps
module erase_seq
  import esq_pkg::*;
#(
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 8,
  parameter int DATA_W    = 8,
  parameter int MAX_RETRY = 3,
  parameter int PULSE_CYC = 2,
  localparam int BLK_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int OFF_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int ADDR_W   = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_erase,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic              cmd_suspend,
  input  logic              cmd_resume,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_rerr,
  output logic [7:0]        sts,
  output logic              done,
  output logic              arr_we,
  output logic              arr_re,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [DATA_W-1:0] arr_rdata
);
  logic              tmr_run, tmr_expire;
  logic              seq_we, seq_re, grant;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_wdata;
  logic [BLK_W-1:0]  tgt_blk;
  logic              is_idle, is_susp, fail_q;

  esq_pulse_timer #(.CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(tmr_run), .expire(tmr_expire)
  );

  esq_ctrl #(
    .BLK_W(BLK_W), .OFF_W(OFF_W), .BLK_WORDS(BLK_WORDS),
    .DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_erase(cmd_erase), .cmd_blk(cmd_blk),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .tmr_expire(tmr_expire), .tmr_run(tmr_run), .rdata(arr_rdata),
    .seq_we(seq_we), .seq_re(seq_re), .seq_addr(seq_addr), .seq_wdata(seq_wdata),
    .tgt_blk(tgt_blk), .is_idle(is_idle), .is_susp(is_susp),
    .fail_q(fail_q), .done_q(done)
  );

  esq_host_gate #(.BLK_W(BLK_W)) u_gate (
    .clk(clk), .rst(rst), .open_win(is_idle || is_susp), .guard_en(is_susp),
    .guard_blk(tgt_blk), .host_rd(host_rd),
    .host_blk(host_addr[ADDR_W-1 -: BLK_W]),
    .grant(grant), .rvalid(host_rvalid), .rerr(host_rerr)
  );

  assign arr_we     = seq_we;
  assign arr_re     = seq_re || grant;
  assign arr_addr   = grant ? host_addr : seq_addr;
  assign arr_wdata  = seq_wdata;
  assign host_rdata = arr_rdata;

  always_comb begin
    sts            = '0;
    sts[STS_READY] = is_idle || is_susp;
    sts[STS_SUSP]  = is_susp;
    sts[STS_EFAIL] = fail_q;
  end
endmodule

// File: rtl/esq_chk.sv
`timescale 1ns/1ps
module esq_chk #(
  parameter int BLK_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       sts,
  input logic             done,
  input logic             cmd_erase,
  input logic [BLK_W-1:0] cmd_blk,
  input logic             host_rd,
  input logic             host_rvalid,
  input logic             host_rerr,
  input logic             arr_we,
  input logic             arr_re,
  input logic [BLK_W-1:0] arr_blk
);
  logic [BLK_W-1:0] lat_blk;

  always_ff @(posedge clk) begin
    if (rst) lat_blk <= '0;
    else if (cmd_erase && sts[7] && !sts[6]) lat_blk <= cmd_blk;
  end

  a_r1_write_in_target: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_blk == lat_blk));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(arr_we && arr_re));

  a_r5_fail_has_done: assert property (@(posedge clk) disable iff (rst)
    sts[5] |-> done);

  a_r6_no_write_when_ready: assert property (@(posedge clk) disable iff (rst)
    sts[7] |-> !arr_we);

  a_r6_susp_is_ready: assert property (@(posedge clk) disable iff (rst)
    sts[6] |-> sts[7]);

  a_r8_reply_needs_request: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid || host_rerr) |-> $past(host_rd));

  a_r8_reply_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(host_rvalid && host_rerr));
endmodule

bind erase_seq esq_chk #(.BLK_W(BLK_W)) u_esq_chk (
  .clk(clk), .rst(rst), .sts(sts), .done(done),
  .cmd_erase(cmd_erase), .cmd_blk(cmd_blk), .host_rd(host_rd),
  .host_rvalid(host_rvalid), .host_rerr(host_rerr),
  .arr_we(arr_we), .arr_re(arr_re), .arr_blk(arr_addr[ADDR_W-1 -: BLK_W])
);

// File: tb/tb_erase_seq.sv
`timescale 1ns/1ps
module tb_erase_seq;
  localparam int NB = 4, BW = 8, DW = 8, MR = 3;
  localparam int AW = 5, DEPTH = NB * BW;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0, host_rd = 0;
  logic [1:0] cmd_blk = '0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_rdata, arr_wdata, arr_rdata;
  logic host_rvalid, host_rerr, done, arr_we, arr_re;
  logic [7:0] sts;
  logic [AW-1:0] arr_addr;

  always #2.5 clk = ~clk;

  erase_seq #(.NUM_BLK(NB), .BLK_WORDS(BW), .DATA_W(DW), .MAX_RETRY(MR), .PULSE_CYC(2)) dut (
    .clk(clk), .rst(rst), .cmd_erase(cmd_erase), .cmd_blk(cmd_blk),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .host_rd(host_rd),
    .host_addr(host_addr), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .host_rerr(host_rerr), .sts(sts), .done(done), .arr_we(arr_we), .arr_re(arr_re),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // behavioural array with fault injection: mode 1 bit0 stuck at 0, 2 bit0 stuck at 1,
  // 3 first all-ones write to the fault word is lost
  logic [DW-1:0] mem [DEPTH];
  logic [1:0] f_mode = '0;
  logic [AW-1:0] f_addr = '0;
  logic fill_req = 1'b0, flaky_used;
  int wr_cnt = 0;

  function automatic logic [DW-1:0] fillv(int i);
    return 8'h5A ^ DW'(i);
  endfunction

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fillv(i);
      flaky_used <= 1'b0;
    end else if (arr_we) begin
      wr_cnt <= wr_cnt + 1;
      if (arr_addr == f_addr && f_mode == 2'd1) mem[arr_addr] <= arr_wdata & ~8'h01;
      else if (arr_addr == f_addr && f_mode == 2'd2) mem[arr_addr] <= arr_wdata | 8'h01;
      else if (arr_addr == f_addr && f_mode == 2'd3 && (&arr_wdata) && !flaky_used)
        flaky_used <= 1'b1;
      else mem[arr_addr] <= arr_wdata;
    end
    if (arr_re) arr_rdata <= mem[arr_addr];
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic refill(input logic [1:0] mode, input logic [AW-1:0] fa);
    @(negedge clk);
    f_mode = mode; f_addr = fa; fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic start_erase(input logic [1:0] b);
    @(negedge clk);
    cmd_erase = 1'b1; cmd_blk = b;
    @(negedge clk);
    cmd_erase = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int k;
    for (k = 0; k < 3000; k++) begin
      if (sts[7] && !sts[6] && done) break;
      @(negedge clk);
    end
    if (k == 3000) chk(req, 32'd0, 32'd1);
  endtask

  function automatic int blk_bad(int b, bit want_ones);
    int bad = 0;
    for (int i = b * BW; i < (b + 1) * BW; i++)
      if (want_ones ? (mem[i] !== 8'hFF) : (mem[i] !== fillv(i))) bad++;
    return bad;
  endfunction

  // vector: blk[22:21] mode[20:19] off[18:16] exp_sts[15:8] exp_writes[7:0]
  localparam logic [22:0] VEC [6] = '{
    {2'd0, 2'd0, 3'd0, 8'h80, 8'd16},
    {2'd3, 2'd0, 3'd0, 8'h80, 8'd16},
    {2'd1, 2'd3, 3'd5, 8'h80, 8'd17},
    {2'd2, 2'd1, 3'd2, 8'hA0, 8'd19},
    {2'd1, 2'd2, 3'd6, 8'hA0, 8'd11},
    {2'd0, 2'd3, 3'd0, 8'h80, 8'd17}
  };

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    refill(2'd0, '0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset sts", sts, 8'h80);
    chk("R10 reset done", done, 0);
    chk("R10 reset strobes", {arr_we, arr_re}, 0);

    foreach (VEC[v]) begin
      logic [1:0] b; logic [1:0] m; logic [2:0] o; logic [7:0] es; logic [7:0] ew;
      {b, m, o, es, ew} = VEC[v];
      refill(m, {b, o});
      base = wr_cnt;
      start_erase(b);
      wait_end("R2 completes");
      chk(es == 8'h80 ? "R3 status" : "R5 fail status", sts, es);
      chk("R5 done", done, 1);
      chk(m == 0 ? "R2 write count" : "R4 retry write count", wr_cnt - base, ew);
      if (es == 8'h80) chk("R3 block all ones", blk_bad(b, 1), 0);
      for (int ob = 0; ob < NB; ob++)
        if (ob != b) chk("R1 other block intact", blk_bad(ob, 0), 0);
    end

    // directed: busy refusal, ignored confirm, suspend mid-pulse, reads, resume
    refill(2'd0, '0);
    base = wr_cnt;
    start_erase(2'd0);
    host_rd = 1'b1; host_addr = 5'd19; cmd_erase = 1'b1; cmd_blk = 2'd3;
    @(negedge clk);
    host_rd = 1'b0; cmd_erase = 1'b0;
    chk("R8 busy read refused", {host_rvalid, host_rerr}, 2'b01);
    while (!arr_we) @(negedge clk);
    cmd_suspend = 1'b1;
    @(negedge clk);
    cmd_suspend = 1'b0;
    chk("R6 no immediate pause", sts[6], 0);
    for (int k = 0; k < 50 && !sts[6]; k++) @(negedge clk);
    chk("R6 suspended status", sts, 8'hC0);
    chk("R6 paused at word boundary", wr_cnt - base, 2);
    repeat (10) @(negedge clk);
    chk("R6 no writes while paused", wr_cnt - base, 2);
    host_rd = 1'b1; host_addr = 5'd19;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R8 other block read", {host_rvalid, host_rerr, host_rdata}, {2'b10, fillv(19)});
    host_rd = 1'b1; host_addr = 5'd4;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R8 target block refused", {host_rvalid, host_rerr}, 2'b01);
    cmd_erase = 1'b1; cmd_blk = 2'd3;
    @(negedge clk);
    cmd_erase = 1'b0;
    chk("R9 confirm ignored while paused", sts, 8'hC0);
    cmd_resume = 1'b1;
    @(negedge clk);
    cmd_resume = 1'b0;
    chk("R7 resume clears flags", sts[7:6], 2'b00);
    wait_end("R7 completes");
    chk("R7 total writes unchanged", wr_cnt - base, 16);
    chk("R3 status after resume", sts, 8'h80);
    chk("R3 block all ones", blk_bad(0, 1), 0);
    chk("R9 ignored block intact", blk_bad(3, 0), 0);
    chk("R8 read block intact", blk_bad(2, 0), 0);

    // reset in the middle of an erase
    start_erase(2'd1);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset mid erase sts", sts, 8'h80);
    chk("R10 reset mid erase done", {done, arr_we}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule